// File: doc/BRIEF.md
# Brightness-Dependent Correction Adder

This block is the per-pixel arithmetic of one colour channel in a display uniformity corrector. Each clock it can accept one video sample together with three signed correction values that an upstream spatial lookup has already resolved for that pixel position. There is one correction value for each of three programmable reference brightness levels: low, middle and high. The block finds where the sample's brightness falls among those levels and interpolates the correction linearly between the two levels around it. Outside the outer levels it holds the correction at the nearer level's value. It adds the result to the sample and saturates the sum to the output range.

There are two width modes. In the narrow mode the sample is 8 bits and the result is 9 bits: the sample is doubled before the addition, so a correction step is half an input step. In the wide mode the sample is 10 bits and so is the result. A bypass control forwards the sample unchanged. Bypass still uses the same alignment and the same latency, so the output timing does not change when it is toggled. A valid flag and a few sync bits travel alongside each sample and arrive with its result.

The division in the interpolation uses a pipelined restoring divider that produces one quotient bit per stage. The block therefore has a fixed latency and accepts a new sample on every clock.

Top module: `luma_corr_adder`

## Requirements
- R1: With `wide_mode`=0 only the low 8 bits of `in_pix`, `lvl_lo`, `lvl_mid` and `lvl_hi` are used and the upper two bits have no effect. The sample is doubled before the addition and `out_pix` stays within 0..511. With `wide_mode`=1 all 10 bits are used and `out_pix` stays within 0..1023.
- R2: `corr_lo`, `corr_mid` and `corr_hi` are 10-bit signed two's complement values in units of one output LSB.
- R3: When the sample is at or below `lvl_lo`, the correction equals `corr_lo`. When it is at or above `lvl_hi`, the correction equals `corr_hi`. The low-level test takes precedence.
- R4: When `lvl_lo` < sample < `lvl_mid`, the correction is `corr_lo + (corr_mid-corr_lo)*(sample-lvl_lo)/(lvl_mid-lvl_lo)`, with the quotient truncated toward zero.
- R5: When `lvl_mid` <= sample < `lvl_hi`, the correction is `corr_mid + (corr_hi-corr_mid)*(sample-lvl_mid)/(lvl_hi-lvl_mid)`, with the quotient truncated toward zero.
- R6: The sum of the aligned sample and the correction saturates to 0 below and to the mode's maximum above. It never wraps.
- R7: With `bypass`=1 the output is the aligned sample: the sample itself in wide mode, or twice its low 8 bits in narrow mode. The corrections have no effect.
- R8: Each accepted sample appears on `out_pix` exactly 23 cycles after the clock edge that captures it. Its `in_sync` bits appear on `out_sync` with it, and `out_valid` marks exactly those cycles. A new sample may be accepted every cycle.
- R9: While reset is held and after it is released, `out_valid`, `out_sync` and `out_pix` are zero until the first result emerges.
- R10: `wide_mode` and `bypass` are captured with each sample, so consecutive samples may use different settings without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sync | input | 2 | Sync bits delayed alongside the sample |
| in_pix | input | 10 | Video sample |
| wide_mode | input | 1 | 1: 10-bit in/out, 0: 8-bit in, 9-bit out |
| bypass | input | 1 | Pass the sample through without correction |
| lvl_lo | input | 10 | Low reference brightness level |
| lvl_mid | input | 10 | Middle reference brightness level |
| lvl_hi | input | 10 | High reference brightness level |
| corr_lo | input | 10 | Signed correction at the low level |
| corr_mid | input | 10 | Signed correction at the middle level |
| corr_hi | input | 10 | Signed correction at the high level |
| out_valid | output | 1 | Result present this cycle |
| out_sync | output | 2 | Delayed sync bits |
| out_pix | output | 10 | Corrected sample |

## Verification
The bench probes samples exactly at each reference level and one step past them. A design with an off-by-one segment test would pick the wrong neighbour's correction there. A falling correction slope with a small fractional quotient separates truncation toward zero from flooring, which would be off by one. Sums pushed past both rails expose wrapping, and narrow-mode samples with the upper input bits set would leak those bits into the result if the mask were missing. Back-to-back samples that alternate mode and bypass, along with a check of the result's cycle, catch settings or sync bits that slip by a stage.

// File: rtl/lca_pkg.sv
package lca_pkg;

    // Which brightness interval a sample falls into
    typedef enum logic [1:0] {
        SEG_BELOW = 2'd0,
        SEG_LOWER = 2'd1,
        SEG_UPPER = 2'd2,
        SEG_ABOVE = 2'd3
    } seg_e;

    // Width mode carried with each sample
    typedef enum logic {
        WM_NARROW = 1'b0,
        WM_WIDE   = 1'b1
    } wmode_e;

endpackage

// File: rtl/lca_front.sv
module lca_front
    import lca_pkg::*;
#(
    parameter int DW     = 10,
    parameter int CW     = 10,
    parameter int SYNC_W = 2,
    parameter int QW     = DW + CW + 1,
    parameter int SBW    = SYNC_W + 3 + CW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [SYNC_W-1:0]    sync_i,
    input  logic [DW-1:0]        pix_i,
    input  logic                 wide_i,
    input  logic                 bypass_i,
    input  logic [DW-1:0]        lvl_lo_i,
    input  logic [DW-1:0]        lvl_mid_i,
    input  logic [DW-1:0]        lvl_hi_i,
    input  logic signed [CW-1:0] corr_lo_i,
    input  logic signed [CW-1:0] corr_mid_i,
    input  logic signed [CW-1:0] corr_hi_i,
    output logic                 v_o,
    output logic [QW-1:0]        nq_o,
    output logic [DW-1:0]        den_o,
    output logic [SBW-1:0]       sb_o
);

    localparam logic [DW-1:0] NAR_MASK = {2'b00, {(DW-2){1'b1}}};
    localparam logic [DW-1:0] ONE_DEN  = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0]        msk, p, lo, mid, hi, off, den, scaled;
    seg_e                 seg;
    logic signed [CW:0]   ext_lo, ext_mid, ext_hi, delta;
    logic signed [CW-1:0] base;
    logic [CW:0]          mag;
    logic                 neg;
    logic [QW-1:0]        prod;

    always_comb begin
        msk = wide_i ? {DW{1'b1}} : NAR_MASK;
        p   = pix_i & msk;
        lo  = lvl_lo_i & msk;
        mid = lvl_mid_i & msk;
        hi  = lvl_hi_i & msk;

        if (p <= lo)       seg = SEG_BELOW;
        else if (p >= hi)  seg = SEG_ABOVE;
        else if (p < mid)  seg = SEG_LOWER;
        else               seg = SEG_UPPER;

        ext_lo  = {corr_lo_i[CW-1],  corr_lo_i};
        ext_mid = {corr_mid_i[CW-1], corr_mid_i};
        ext_hi  = {corr_hi_i[CW-1],  corr_hi_i};

        base  = corr_lo_i;
        delta = '0;
        off   = '0;
        den   = ONE_DEN;
        unique case (seg)
            SEG_BELOW: begin
                base = corr_lo_i;
            end
            SEG_LOWER: begin
                base  = corr_lo_i;
                delta = ext_mid - ext_lo;
                off   = p - lo;
                den   = mid - lo;
            end
            SEG_UPPER: begin
                base  = corr_mid_i;
                delta = ext_hi - ext_mid;
                off   = p - mid;
                den   = hi - mid;
            end
            SEG_ABOVE: begin
                base = corr_hi_i;
            end
        endcase

        neg    = delta[CW];
        mag    = neg ? $unsigned(-delta) : $unsigned(delta);
        prod   = QW'(mag) * QW'(off);
        scaled = wide_i ? p : {p[DW-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            nq_o  <= '0;
            den_o <= '0;
            sb_o  <= '0;
        end else begin
            v_o   <= valid_i;
            nq_o  <= prod;
            den_o <= den;
            sb_o  <= {sync_i, bypass_i, wide_i, neg, base, scaled};
        end
    end

    // R8: every accepted sample enters the pipeline on the next cycle
    a_r8_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> v_o);

    // R4/R5: a divisor of zero never enters the divider
    a_r4_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> den_o != '0);

endmodule

// File: rtl/lca_div_stage.sv
module lca_div_stage #(
    parameter int QW  = 21,
    parameter int DW  = 10,
    parameter int SBW = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           v_i,
    input  logic [QW-1:0]  nq_i,
    input  logic [DW-1:0]  rem_i,
    input  logic [DW-1:0]  den_i,
    input  logic [SBW-1:0] sb_i,
    output logic           v_o,
    output logic [QW-1:0]  nq_o,
    output logic [DW-1:0]  rem_o,
    output logic [DW-1:0]  den_o,
    output logic [SBW-1:0] sb_o
);

    logic [DW:0]   trial, diff;
    logic          fits;
    logic [DW-1:0] nxt_rem;

    always_comb begin
        trial   = {rem_i, nq_i[QW-1]};
        fits    = trial >= {1'b0, den_i};
        diff    = trial - {1'b0, den_i};
        nxt_rem = fits ? diff[DW-1:0] : trial[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            nq_o  <= '0;
            rem_o <= '0;
            den_o <= '0;
            sb_o  <= '0;
        end else begin
            v_o   <= v_i;
            nq_o  <= {nq_i[QW-2:0], fits};
            rem_o <= nxt_rem;
            den_o <= den_i;
            sb_o  <= sb_i;
        end
    end

    // R4/R5: the partial remainder stays below the divisor at every stage
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> rem_o < den_o);

    // R8: stages neither drop nor invent samples
    a_r8_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> v_o);

endmodule

// File: rtl/lca_finish.sv
module lca_finish
    import lca_pkg::*;
#(
    parameter int DW     = 10,
    parameter int CW     = 10,
    parameter int SYNC_W = 2,
    parameter int QW     = DW + CW + 1,
    parameter int SBW    = SYNC_W + 3 + CW + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  logic [QW-1:0]     q_i,
    input  logic [SBW-1:0]    sb_i,
    output logic              out_valid_o,
    output logic [SYNC_W-1:0] out_sync_o,
    output logic [DW-1:0]     out_pix_o
);

    localparam int SW = QW + 2;

    logic [SYNC_W-1:0]    sync_s;
    logic                 byp_s, wide_s, neg_s;
    logic signed [CW-1:0] base_s;
    logic [DW-1:0]        scaled_s;

    assign {sync_s, byp_s, wide_s, neg_s, base_s, scaled_s} = sb_i;

    wmode_e               wm;
    logic signed [SW-1:0] pix_x, base_x, q_x, corr_x, sum_x, max_x;
    logic [DW-1:0]        sat;

    always_comb begin
        pix_x  = $signed({{(SW-DW){1'b0}}, scaled_s});
        base_x = $signed({{(SW-CW){base_s[CW-1]}}, base_s});
        q_x    = $signed({2'b00, q_i});
        corr_x = neg_s ? (base_x - q_x) : (base_x + q_x);
        wm     = wmode_e'(wide_s);
        unique case (wm)
            WM_NARROW: max_x = $signed({{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}});
            WM_WIDE:   max_x = $signed({{(SW-DW){1'b0}}, {DW{1'b1}}});
        endcase
        sum_x = byp_s ? pix_x : (pix_x + corr_x);
        if (sum_x[SW-1])        sat = '0;
        else if (sum_x > max_x) sat = max_x[DW-1:0];
        else                    sat = sum_x[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_sync_o  <= '0;
            out_pix_o   <= '0;
        end else begin
            out_valid_o <= v_i;
            out_sync_o  <= sync_s;
            out_pix_o   <= sat;
        end
    end

    // R1: narrow mode results never use the top output bit
    a_r1_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        v_i && !wide_s |=> out_pix_o[DW-1] == 1'b0);

    // R6: a non-negative correction never lowers the sample (no wrap)
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        v_i && !byp_s && !corr_x[SW-1] |=> out_pix_o >= $past(scaled_s));

    // R6: a negative correction never raises the sample (no wrap)
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        v_i && !byp_s && corr_x[SW-1] |=> out_pix_o <= $past(scaled_s));

endmodule

// File: rtl/luma_corr_adder.sv
module luma_corr_adder #(
    parameter int DW     = 10,
    parameter int CW     = 10,
    parameter int SYNC_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SYNC_W-1:0]    in_sync,
    input  logic [DW-1:0]        in_pix,
    input  logic                 wide_mode,
    input  logic                 bypass,
    input  logic [DW-1:0]        lvl_lo,
    input  logic [DW-1:0]        lvl_mid,
    input  logic [DW-1:0]        lvl_hi,
    input  logic signed [CW-1:0] corr_lo,
    input  logic signed [CW-1:0] corr_mid,
    input  logic signed [CW-1:0] corr_hi,
    output logic                 out_valid,
    output logic [SYNC_W-1:0]    out_sync,
    output logic [DW-1:0]        out_pix
);

    localparam int QW  = DW + CW + 1;
    localparam int SBW = SYNC_W + 3 + CW + DW;

    logic           v_a   [QW+1];
    logic [QW-1:0]  nq_a  [QW+1];
    logic [DW-1:0]  rem_a [QW+1];
    logic [DW-1:0]  den_a [QW+1];
    logic [SBW-1:0] sb_a  [QW+1];

    assign rem_a[0] = '0;

    lca_front #(
        .DW(DW), .CW(CW), .SYNC_W(SYNC_W), .QW(QW), .SBW(SBW)
    ) front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (in_valid),
        .sync_i     (in_sync),
        .pix_i      (in_pix),
        .wide_i     (wide_mode),
        .bypass_i   (bypass),
        .lvl_lo_i   (lvl_lo),
        .lvl_mid_i  (lvl_mid),
        .lvl_hi_i   (lvl_hi),
        .corr_lo_i  (corr_lo),
        .corr_mid_i (corr_mid),
        .corr_hi_i  (corr_hi),
        .v_o        (v_a[0]),
        .nq_o       (nq_a[0]),
        .den_o      (den_a[0]),
        .sb_o       (sb_a[0])
    );

    for (genvar g = 0; g < QW; g++) begin : g_div
        lca_div_stage #(.QW(QW), .DW(DW), .SBW(SBW)) stage_i (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (v_a[g]),
            .nq_i  (nq_a[g]),
            .rem_i (rem_a[g]),
            .den_i (den_a[g]),
            .sb_i  (sb_a[g]),
            .v_o   (v_a[g+1]),
            .nq_o  (nq_a[g+1]),
            .rem_o (rem_a[g+1]),
            .den_o (den_a[g+1]),
            .sb_o  (sb_a[g+1])
        );
    end

    lca_finish #(
        .DW(DW), .CW(CW), .SYNC_W(SYNC_W), .QW(QW), .SBW(SBW)
    ) finish_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .v_i         (v_a[QW]),
        .q_i         (nq_a[QW]),
        .sb_i        (sb_a[QW]),
        .out_valid_o (out_valid),
        .out_sync_o  (out_sync),
        .out_pix_o   (out_pix)
    );

    // R4/R5: the final remainder is a proper remainder of the division
    a_r4_final_rem: assert property (@(posedge clk) disable iff (!rst_n)
        v_a[QW] |-> rem_a[QW] < den_a[QW]);

    // R9: no result is reported on the first cycle out of reset
    a_r9_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/luma_corr_adder_tb_top.sv
`timescale 1ns/1ps
module luma_corr_adder_tb_top;

    localparam int LAT = 23;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_sync = '0;
    logic [9:0]        in_pix = '0;
    logic              wide_mode = 1'b1;
    logic              bypass = 1'b0;
    logic [9:0]        lvl_lo = '0, lvl_mid = '0, lvl_hi = '0;
    logic signed [9:0] corr_lo = '0, corr_mid = '0, corr_hi = '0;
    logic              out_valid;
    logic [1:0]        out_sync;
    logic [9:0]        out_pix;

    luma_corr_adder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_pix(in_pix), .wide_mode(wide_mode), .bypass(bypass),
        .lvl_lo(lvl_lo), .lvl_mid(lvl_mid), .lvl_hi(lvl_hi),
        .corr_lo(corr_lo), .corr_mid(corr_mid), .corr_hi(corr_hi),
        .out_valid(out_valid), .out_sync(out_sync), .out_pix(out_pix)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    pix;
        int    sync;
        int    t;
        string req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input int p0, input int lo0, input int mid0, input int hi0,
                                 input int clo, input int cmid, input int chi,
                                 input bit wide, input bit byp);
        int msk, p, lo, mid, hi, sc, mx, c, s;
        msk = wide ? 1023 : 255;
        p = p0 & msk; lo = lo0 & msk; mid = mid0 & msk; hi = hi0 & msk;
        sc = wide ? p : 2 * p;
        mx = wide ? 1023 : 511;
        if (byp) return sc;
        if (p <= lo)      c = clo;
        else if (p >= hi) c = chi;
        else if (p < mid) c = clo + ((cmid - clo) * (p - lo)) / (mid - lo);
        else              c = cmid + ((chi - cmid) * (p - mid)) / (hi - mid);
        s = sc + c;
        if (s < 0) s = 0;
        if (s > mx) s = mx;
        return s;
    endfunction

    // Driver: presents one sample and records its expected result
    task automatic send(input int p, input int lo, input int mid, input int hi,
                        input int clo, input int cmid, input int chi,
                        input bit wide, input bit byp, input int sy, input string req);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_pix    = p[9:0];
        lvl_lo    = lo[9:0];
        lvl_mid   = mid[9:0];
        lvl_hi    = hi[9:0];
        corr_lo   = clo[9:0];
        corr_mid  = cmid[9:0];
        corr_hi   = chi[9:0];
        wide_mode = wide;
        bypass    = byp;
        in_sync   = sy[1:0];
        e.pix  = model(p, lo, mid, hi, clo, cmid, chi, wide, byp);
        e.sync = sy & 3;
        e.t    = cyc;
        e.req  = req;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pix   = 10'h3ff;
            corr_hi  = 10'sd300;
        end
    endtask

    // Monitor: compares each result against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                chk("R8", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.req, "out_pix", int'(out_pix), e.pix);
                chk("R8", "out_sync", int'(out_sync), e.sync);
                chk("R8", "latency", cyc - e.t, LAT);
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("WATCHDOG", "run completed", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet while in reset
        chk("R9", "out_valid in reset", int'(out_valid), 0);
        chk("R9", "out_pix in reset", int'(out_pix), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "out_valid after reset", int'(out_valid), 0);
        chk("R9", "out_sync after reset", int'(out_sync), 0);
        chk("R9", "out_pix after reset", int'(out_pix), 0);

        // R3: clamping at and beyond the outer levels (wide mode)
        send(100, 200, 500, 800, -40, 10, 100, 1, 0, 1, "R3");
        send(200, 200, 500, 800, -40, 10, 100, 1, 0, 2, "R3");
        send(800, 200, 500, 800, -40, 10, 100, 1, 0, 3, "R3");
        send(900, 200, 500, 800, -40, 10, 100, 1, 0, 0, "R3");
        // R4: lower segment, rising and falling slopes, truncation toward zero
        send(350, 200, 500, 800, -40, 10, 100, 1, 0, 1, "R4");
        send(201, 200, 500, 800, -40, 10, 100, 1, 0, 2, "R4");
        send(203, 200, 500, 800, 60, -60, 100, 1, 0, 3, "R4");
        send(499, 200, 500, 800, 60, -60, 100, 1, 0, 0, "R4");
        // R5: upper segment, including the middle level itself
        send(500, 200, 500, 800, -40, 10, 100, 1, 0, 1, "R5");
        send(650, 200, 500, 800, -40, 10, 100, 1, 0, 2, "R5");
        send(799, 200, 500, 800, 0, 511, -512, 1, 0, 3, "R5");
        send(501, 200, 500, 800, 0, 300, -300, 1, 0, 0, "R5");
        // R6: saturation at both rails, R2 extreme signed values
        send(1000, 200, 500, 800, -40, 10, 100, 1, 0, 1, "R6");
        send(10, 200, 500, 800, -40, 10, 100, 1, 0, 2, "R6");
        send(1020, 200, 500, 800, 511, 511, 511, 1, 0, 3, "R2");
        send(300, 400, 500, 800, -512, 10, 100, 1, 0, 0, "R2");
        // R1: narrow mode, upper bits of sample and levels ignored
        send(10'h3ff, 50, 128, 200, 0, 5, 100, 0, 0, 1, "R1");
        send(10'h2f0, 10'h332, 128, 200, 0, 5, 20, 0, 0, 2, "R1");
        send(10'h0f0, 10'h032, 128, 200, 0, 5, 20, 0, 0, 3, "R1");
        send(90, 50, 128, 10'h3c8, -7, 9, 20, 0, 0, 0, "R1");
        send(20, 50, 128, 200, -100, 9, 20, 0, 0, 1, "R6");
        // R7: bypass in both modes ignores corrections
        send(777, 200, 500, 800, -512, -512, -512, 1, 1, 2, "R7");
        send(10'h3c8, 50, 128, 200, 511, 511, 511, 0, 1, 3, "R7");
        // R10: settings alternate sample to sample
        for (int i = 0; i < 8; i++)
            send(150 + 37 * i, 60, 140, 220, -30, 25, 70, i[0], i[1], i, "R10");
        idle(30);
        chk("R8", "queue drained after idle", sbq.size(), 0);

        // Random sweep over valid level orderings
        for (int i = 0; i < 300; i++) begin
            int lo, mid, hi, w;
            w = int'($urandom_range(0, 1));
            if (w != 0) begin
                lo  = int'($urandom_range(0, 300));
                mid = lo + 1 + int'($urandom_range(0, 300));
                hi  = mid + 1 + int'($urandom_range(0, 400));
            end else begin
                lo  = int'($urandom_range(0, 80));
                mid = lo + 1 + int'($urandom_range(0, 80));
                hi  = mid + 1 + int'($urandom_range(0, 80));
            end
            send(int'($urandom_range(0, 1023)), lo, mid, hi,
                 int'($urandom_range(0, 1023)) - 512,
                 int'($urandom_range(0, 1023)) - 512,
                 int'($urandom_range(0, 1023)) - 512,
                 w[0], (i % 17) == 0, i, (i % 2 == 0) ? "R4" : "R5");
        end
        idle(40);
        chk("R8", "all results delivered", sbq.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule